// File: doc/BRIEF.md
# Programmable Clock Post-Divider and Output Router

This block sits between a frequency-synthesis loop and the chip's clock pins. It runs on the synthesizer clock. It oversamples a slower reference clock. From these two it builds two clock outputs:

- A main output, which can carry the synthesizer clock after an even post-division, the plain reference, or the reference after the same even division.
- A second output, which can carry the reference, the reference halved, the main output, or the main output halved.

The block holds two configuration profiles side by side. Each profile has:

- a post-divide setting;
- a reference-divide ratio;
- a feedback ratio;
- a source code for each of the two outputs.

The block passes the reference and feedback ratios of the active profile to the external loop.

One shared pin can take any of four roles, chosen by a mode field:

- an output-enable input;
- a sleep (power-down) input;
- a profile-select input;
- the output pin of the second clock.

The pin is brought through a two-flop synchronizer before use. Output multiplexing has no glitches. Profile switches wait for the end of a full post-divider period. Leaving sleep holds the outputs low for a programmable number of reference edges. After that, all counters restart from their reset state.

Top module: `ckr_top`

## Requirements
- R1: A profile is a 28-bit word with these fields:
  - bits 4:0 hold the post-divide setting P;
  - bits 12:5 hold the reference ratio R;
  - bits 23:13 hold the feedback setting M;
  - bits 25:24 hold the main-output source code;
  - bits 27:26 hold the second-output source code.

  With the synthesizer source selected, the main output has a period of 2*P clock cycles and is high for P of them. A setting of P=0 behaves as P=1.
- R2: Main-output source codes are: 0 or 3 selects the post-divided synthesizer clock, 1 selects the reference, and 2 selects the reference divided by 2*P.
- R3: Second-output source codes are: 0 selects the reference, 1 the reference divided by 2, 2 the main output, and 3 the main output divided by 2.
- R4: The pin mode field uses these codes: 0 enable, 1 sleep, 2 profile select, 3 clock out. In mode 3 the second clock drives `pin_o` and `pin_oe_o` is 1. In modes 0, 1 and 2, `pin_oe_o` is 0.
- R5: In enable mode, a low pin drives `clk0_oe_o` to 0 and a high pin drives it to 1. In every other mode `clk0_oe_o` is 1. `clk0_oe_o` changes only in a cycle that follows a low `clk0_o`.
- R6: In sleep mode, a low pin holds both clock outputs low and the counters in reset. After the pin returns high, the outputs stay low until the wake count of reference rising edges has passed. Then the outputs restart.
- R7: In profile-select mode, a low pin selects profile B and a high pin selects profile A. In all other modes, profile A is active. A switch is applied only at the end of a complete post-divider period. Every high and low phase of a synthesizer-sourced main output therefore has the width of one of the two settings.
- R8: When the source code of an output changes, every high pulse on that output is either a whole pulse of the old source or a whole pulse of the new one.
- R9: `ref_ratio_o` equals R of the active profile, and `fb_ratio_o` equals 2*M.
- R10: While reset is high, `clk0_o` is 0, `pin_o` is 0 and `clk0_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synthesizer clock; all logic runs on it |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock level, oversampled |
| pin_i | input | 1 | Level read from the shared pin |
| cfg_prof_a_i | input | 28 | Profile A word |
| cfg_prof_b_i | input | 28 | Profile B word |
| cfg_pin_mode_i | input | 2 | Role of the shared pin |
| cfg_wake_i | input | WAKE_W | Reference edges to wait after sleep |
| clk0_o | output | 1 | Main clock output |
| clk0_oe_o | output | 1 | Main output driver enable |
| pin_o | output | 1 | Second clock, driven onto the shared pin |
| pin_oe_o | output | 1 | Shared pin driver enable |
| ref_ratio_o | output | 8 | Reference ratio for the external loop |
| fb_ratio_o | output | 12 | Feedback ratio for the external loop |

## Verification
The properties assume the following about the inputs:
- The configuration words and pin mode change only while reset is high.
- The reference toggles no faster than every second synthesizer cycle, so every edge of it is seen.

The stimulus meets these assumptions in three ways:
- It loads each new configuration only during a reset of several cycles.
- It runs the reference at one sixth of the clock rate.
- It moves the shared pin only on falling clock edges, leaving the synchronizer to handle the asynchronous timing.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    localparam int P_W    = 5;
    localparam int R_W    = 8;
    localparam int M_W    = 11;
    localparam int SEL_W  = 2;
    localparam int FB_W   = M_W + 1;
    localparam int PROF_W = P_W + R_W + M_W + 2 * SEL_W;
    localparam int C0_N   = 3;
    localparam int C1_N   = 4;

    typedef enum logic [1:0] {
        PM_ENABLE = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_SELECT = 2'd2,
        PM_CLKOUT = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        C0_SYN     = 2'd0,
        C0_REF     = 2'd1,
        C0_REFDIV  = 2'd2,
        C0_SYN_ALT = 2'd3
    } c0_src_e;

    typedef enum logic [1:0] {
        C1_REF    = 2'd0,
        C1_REF_H  = 2'd1,
        C1_CLK0   = 2'd2,
        C1_CLK0_H = 2'd3
    } c1_src_e;

    typedef enum logic [1:0] {
        SQ_RUN   = 2'd0,
        SQ_SLEEP = 2'd1,
        SQ_WAKE  = 2'd2
    } seq_e;

    typedef struct packed {
        c1_src_e        c1;
        c0_src_e        c0;
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [P_W-1:0] p;
    } prof_t;

    // A zero post-divide setting would give no division at all; use 1.
    function automatic logic [P_W-1:0] eff_half(input logic [P_W-1:0] p);
        return (p == '0) ? P_W'(1) : p;
    endfunction

    // Source code 3 of the main output aliases the synthesizer path.
    function automatic logic [SEL_W-1:0] c0_index(input c0_src_e s);
        return (s == C0_SYN_ALT) ? SEL_W'(C0_SYN) : SEL_W'(s);
    endfunction

endpackage

// File: rtl/ckr_div2n.sv
module ckr_div2n #(
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic [CW-1:0] half_i,
    output logic          lvl_o,
    output logic          tc_o
);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          wrap;

    // ">=" keeps the counter sane if the half period shrinks mid-phase.
    assign wrap = tick_i && (cnt_q >= half_i - CW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign lvl_o = lvl_q;
    // End of a complete period: the high phase is finishing.
    assign tc_o  = wrap && lvl_q;

endmodule

// File: rtl/ckr_gfmux.sv
module ckr_gfmux #(
    parameter int N  = 3,
    parameter int SW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [N-1:0]  src_i,
    input  logic [SW-1:0] sel_i,
    output logic          out_o
);

    logic [SW-1:0] cur_q;
    logic          park_q;
    logic          out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q  <= sel_i;
            park_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (park_q) begin
            // Hold low; adopt the new source only while it is low.
            out_q <= 1'b0;
            if (!src_i[sel_i]) begin
                cur_q  <= sel_i;
                park_q <= 1'b0;
            end
        end else if ((sel_i != cur_q) && !out_q) begin
            // Old source is in its low phase: leave it here.
            park_q <= 1'b1;
            out_q  <= 1'b0;
        end else begin
            out_q <= src_i[cur_q];
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/ckr_pwrseq.sv
module ckr_pwrseq
    import ckr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          sleep_req_i,
    input  logic          ref_rise_i,
    input  logic [CW-1:0] wake_i,
    output logic          run_o
);

    seq_e          st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= SQ_RUN;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SQ_RUN: begin
                    if (sleep_req_i) st_q <= SQ_SLEEP;
                end
                SQ_SLEEP: begin
                    if (!sleep_req_i) begin
                        st_q  <= SQ_WAKE;
                        cnt_q <= '0;
                    end
                end
                SQ_WAKE: begin
                    if (sleep_req_i) begin
                        st_q <= SQ_SLEEP;
                    end else if (cnt_q >= wake_i) begin
                        st_q <= SQ_RUN;
                    end else if (ref_rise_i) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: st_q <= SQ_RUN;
            endcase
        end
    end

    assign run_o = (st_q == SQ_RUN);

endmodule

// File: rtl/ckr_top.sv
module ckr_top
    import ckr_pkg::*;
#(
    parameter int WAKE_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_i,
    input  logic              pin_i,
    input  logic [PROF_W-1:0] cfg_prof_a_i,
    input  logic [PROF_W-1:0] cfg_prof_b_i,
    input  logic [1:0]        cfg_pin_mode_i,
    input  logic [WAKE_W-1:0] cfg_wake_i,
    output logic              clk0_o,
    output logic              clk0_oe_o,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic [R_W-1:0]    ref_ratio_o,
    output logic [FB_W-1:0]   fb_ratio_o
);

    // Pin synchronizer; idle level is high, matching an undriven pin.
    logic [SYNC_N-1:0] pin_sync_q;
    logic              pin_s;

    always_ff @(posedge clk_i) begin
        if (rst_i) pin_sync_q <= '1;
        else       pin_sync_q <= {pin_sync_q[SYNC_N-2:0], pin_i};
    end
    assign pin_s = pin_sync_q[SYNC_N-1];

    // Role decode of the shared pin.
    pin_mode_e mode;
    logic      oe_req, sleep_req, want_b;

    assign mode      = pin_mode_e'(cfg_pin_mode_i);
    assign oe_req    = (mode == PM_ENABLE) ? pin_s : 1'b1;
    assign sleep_req = (mode == PM_SLEEP) && !pin_s;
    assign want_b    = (mode == PM_SELECT) && !pin_s;

    // Reference oversampling and edge detect.
    logic ref_q, ref_qq, ref_rise;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_q  <= 1'b0;
            ref_qq <= 1'b0;
        end else begin
            ref_q  <= ref_i;
            ref_qq <= ref_q;
        end
    end
    assign ref_rise = ref_q && !ref_qq;

    // Sleep / wake sequencing.
    logic run, srst;

    ckr_pwrseq #(.CW(WAKE_W)) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sleep_req_i (sleep_req),
        .ref_rise_i  (ref_rise),
        .wake_i      (cfg_wake_i),
        .run_o       (run)
    );
    assign srst = rst_i || !run;

    // Active profile, switched only at a post-divider period boundary.
    prof_t          prof_a, prof_b, act;
    logic           prof_sel;
    logic           syn_tc;
    logic [P_W-1:0] half;

    assign prof_a = prof_t'(cfg_prof_a_i);
    assign prof_b = prof_t'(cfg_prof_b_i);
    assign act    = prof_sel ? prof_b : prof_a;
    assign half   = eff_half(act.p);

    always_ff @(posedge clk_i) begin
        if (srst)                             prof_sel <= want_b;
        else if (syn_tc && prof_sel != want_b) prof_sel <= want_b;
    end

    // Dividers.
    logic syn_lvl, ref_div, ref_tc_unused, ref_h;

    ckr_div2n #(.CW(P_W)) u_syn_div (
        .clk_i  (clk_i),
        .rst_i  (srst),
        .tick_i (1'b1),
        .half_i (half),
        .lvl_o  (syn_lvl),
        .tc_o   (syn_tc)
    );

    ckr_div2n #(.CW(P_W)) u_ref_div (
        .clk_i  (clk_i),
        .rst_i  (srst),
        .tick_i (ref_rise),
        .half_i (half),
        .lvl_o  (ref_div),
        .tc_o   (ref_tc_unused)
    );

    always_ff @(posedge clk_i) begin
        if (srst)          ref_h <= 1'b0;
        else if (ref_rise) ref_h <= ~ref_h;
    end

    // Main output mux.
    logic [C0_N-1:0] c0_src;
    logic            clk0;

    assign c0_src = {ref_div, ref_q, syn_lvl};

    ckr_gfmux #(.N(C0_N), .SW(SEL_W)) u_c0_mux (
        .clk_i (clk_i),
        .rst_i (srst),
        .src_i (c0_src),
        .sel_i (c0_index(act.c0)),
        .out_o (clk0)
    );

    // Main output halved.
    logic clk0_prev, c0_half;

    always_ff @(posedge clk_i) begin
        if (srst) begin
            clk0_prev <= 1'b0;
            c0_half   <= 1'b0;
        end else begin
            clk0_prev <= clk0;
            if (clk0 && !clk0_prev) c0_half <= ~c0_half;
        end
    end

    // Second output mux.
    logic [C1_N-1:0] c1_src;
    logic            clk1;

    assign c1_src = {c0_half, clk0, ref_h, ref_q};

    ckr_gfmux #(.N(C1_N), .SW(SEL_W)) u_c1_mux (
        .clk_i (clk_i),
        .rst_i (srst),
        .src_i (c1_src),
        .sel_i (SEL_W'(act.c1)),
        .out_o (clk1)
    );

    // Output-enable applied only while the main output is low.
    logic clk0_oe_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      clk0_oe_q <= 1'b0;
        else if (!clk0) clk0_oe_q <= oe_req;
    end

    assign clk0_o      = clk0;
    assign clk0_oe_o   = clk0_oe_q;
    assign pin_o       = clk1;
    assign pin_oe_o    = (mode == PM_CLKOUT);
    assign ref_ratio_o = act.r;
    assign fb_ratio_o  = {act.m, 1'b0};

endmodule

// File: rtl/ckr_chk.sv
module ckr_chk (
    input logic clk,
    input logic rst,
    input logic clk0,
    input logic clk0_oe,
    input logic run,
    input logic prof_sel,
    input logic syn_tc,
    input logic c0_half
);

    // R5
    oe_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk0_oe) |-> !$past(clk0));

    // R6
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !clk0);

    // R7
    switch_at_tc_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(prof_sel) |-> $past(syn_tc || !run));

    // R3
    half_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(c0_half) |-> (!$past(run) || ($past(clk0) && !$past(clk0, 2))));

endmodule

bind ckr_top ckr_chk u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .clk0     (clk0),
    .clk0_oe  (clk0_oe_q),
    .run      (run),
    .prof_sel (prof_sel),
    .syn_tc   (syn_tc),
    .c0_half  (c0_half)
);

// File: tb/tb_ckr_top.sv
module tb_ckr_top;
    import ckr_pkg::*;

    logic              clk_i = 1'b0;
    logic              rst_i = 1'b1;
    logic              ref_i = 1'b0;
    logic              pin_i = 1'b1;
    logic [PROF_W-1:0] pa = '0;
    logic [PROF_W-1:0] pb = '0;
    logic [1:0]        pmode = 2'd3;
    logic [7:0]        wake = 8'd0;
    logic              clk0_o, clk0_oe_o, pin_o, pin_oe_o;
    logic [R_W-1:0]    ref_ratio_o;
    logic [FB_W-1:0]   fb_ratio_o;

    ckr_top dut (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .ref_i          (ref_i),
        .pin_i          (pin_i),
        .cfg_prof_a_i   (pa),
        .cfg_prof_b_i   (pb),
        .cfg_pin_mode_i (pmode),
        .cfg_wake_i     (wake),
        .clk0_o         (clk0_o),
        .clk0_oe_o      (clk0_oe_o),
        .pin_o          (pin_o),
        .pin_oe_o       (pin_oe_o),
        .ref_ratio_o    (ref_ratio_o),
        .fb_ratio_o     (fb_ratio_o)
    );

    always #2 clk_i = ~clk_i;

    // Reference: period of six clock cycles.
    int rph = 0;
    always @(negedge clk_i) begin
        if (rph == 2) begin
            rph   <= 0;
            ref_i <= ~ref_i;
        end else begin
            rph <= rph + 1;
        end
    end

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    function automatic logic [PROF_W-1:0] mk(input int p, input int c0, input int c1,
                                               input int r, input int m);
        return {SEL_W'(c1), SEL_W'(c0), M_W'(m), R_W'(r), P_W'(p)};
    endfunction

    function automatic logic sig(input bit which);
        return which ? pin_o : clk0_o;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic start(input logic [PROF_W-1:0] a, input logic [PROF_W-1:0] b,
                         input int mode, input int wk);
        @(negedge clk_i);
        pa = a; pb = b; pmode = 2'(mode); wake = 8'(wk);
        rst_i = 1'b1;
        cyc(4);
        rst_i = 1'b0;
    endtask

    task automatic meas(input bit which, output int per, output int hi);
        int t = 0;
        while (sig(which) == 1'b1 && t < 1000) begin @(negedge clk_i); t++; end
        while (sig(which) == 1'b0 && t < 1000) begin @(negedge clk_i); t++; end
        hi = 0;
        while (sig(which) == 1'b1 && t < 1000) begin hi++; @(negedge clk_i); t++; end
        per = hi;
        while (sig(which) == 1'b0 && t < 1000) begin per++; @(negedge clk_i); t++; end
    endtask

    // Run n cycles, moving the pin at t1 (low) and t2 (high); collect phase widths.
    task automatic watch(input int n, input int t1, input int t2, input int w1, input int w2,
                         input bit lows, output int bad, output int pulses);
        int  len = 0;
        bit  prev;
        bit  started = 0;
        bad = 0; pulses = 0;
        prev = clk0_o;
        for (int i = 0; i < n; i++) begin
            if (i == t1) pin_i = 1'b0;
            if (i == t2) pin_i = 1'b1;
            @(negedge clk_i);
            if (clk0_o != prev) begin
                if (started && (prev || lows)) begin
                    if (len != w1 && len != w2) bad++;
                end
                if (started && prev) pulses++;
                started = 1;
                len = 1;
            end else begin
                len++;
            end
            prev = clk0_o;
        end
    endtask

    // p, c0, c1, r, m, clk0 period, clk0 high, clk1 period, clk1 high
    localparam int NV = 6;
    localparam int VT [NV][9] = '{
        '{ 3, 0, 3,  10,  100,  6,  3,  12,  6},
        '{ 0, 0, 2,   1, 2047,  2,  1,   2,  1},
        '{ 5, 1, 1, 255,    1,  6,  3,  12,  6},
        '{ 2, 2, 0,   7,   33, 24, 12,   6,  3},
        '{31, 3, 3, 128, 1024, 62, 31, 124, 62},
        '{ 1, 2, 3,   2,  500, 12,  6,  24, 12}
    };

    initial begin
        repeat (150000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int per, hi, bad, pulses, viol, t;
        bit prev_c, prev_oe;

        // R10: state while reset is held
        pa = mk(3, 0, 3, 10, 100); pmode = 2'd3; rst_i = 1'b1;
        cyc(6);
        chk(clk0_o == 1'b0, "R10 clk0_o in reset", int'(clk0_o), 0);
        chk(pin_o == 1'b0, "R10 pin_o in reset", int'(pin_o), 0);
        chk(clk0_oe_o == 1'b0, "R10 clk0_oe_o in reset", int'(clk0_oe_o), 0);
        rst_i = 1'b0;
        cyc(5);
        chk(clk0_oe_o == 1'b1, "R5 enable outside enable mode", int'(clk0_oe_o), 1);

        // R1 R2 R3 R4 R9: table of profiles in clock-out mode
        for (int v = 0; v < NV; v++) begin
            pin_i = 1'b1;
            start(mk(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4]),
                  mk(4, 0, 0, 1, 1), 3, 0);
            cyc(150);
            chk(pin_oe_o == 1'b1, "R4 pin driven in clock-out mode", int'(pin_oe_o), 1);
            chk(ref_ratio_o == R_W'(VT[v][3]), "R9 reference ratio", int'(ref_ratio_o), VT[v][3]);
            chk(fb_ratio_o == FB_W'(2 * VT[v][4]), "R9 feedback ratio", int'(fb_ratio_o), 2 * VT[v][4]);
            meas(1'b0, per, hi);
            chk(per == VT[v][5], "R1 R2 clk0 period", per, VT[v][5]);
            chk(hi == VT[v][6], "R1 R2 clk0 high width", hi, VT[v][6]);
            meas(1'b1, per, hi);
            chk(per == VT[v][7], "R3 clk1 period", per, VT[v][7]);
            chk(hi == VT[v][8], "R3 clk1 high width", hi, VT[v][8]);
        end

        // R5 R4: enable mode
        pin_i = 1'b1;
        start(mk(4, 0, 0, 3, 3), mk(4, 0, 0, 3, 3), 0, 0);
        cyc(30);
        chk(pin_oe_o == 1'b0, "R4 pin is input in enable mode", int'(pin_oe_o), 0);
        chk(clk0_oe_o == 1'b1, "R5 enabled with pin high", int'(clk0_oe_o), 1);
        viol = 0;
        for (int ph = 0; ph < 2; ph++) begin
            pin_i = (ph == 0) ? 1'b0 : 1'b1;
            prev_c = clk0_o; prev_oe = clk0_oe_o;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk_i);
                if (clk0_oe_o != prev_oe && prev_c) viol++;
                prev_c = clk0_o; prev_oe = clk0_oe_o;
            end
            chk(clk0_oe_o == pin_i, "R5 enable follows pin", int'(clk0_oe_o), int'(pin_i));
        end
        chk(viol == 0, "R5 enable changed while clk0 high", viol, 0);

        // R6: sleep and wake
        pin_i = 1'b1;
        start(mk(3, 0, 2, 3, 3), mk(3, 0, 2, 3, 3), 1, 8);
        cyc(30);
        pin_i = 1'b0;
        cyc(10);
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk_i);
            if (clk0_o || pin_o) hi++;
        end
        chk(hi == 0, "R6 outputs low in sleep", hi, 0);
        pin_i = 1'b1;
        t = 0;
        while (clk0_o == 1'b0 && t < 500) begin @(negedge clk_i); t++; end
        chk(t >= 42 && t <= 63, "R6 wake delay in cycles", t, 51);
        meas(1'b0, per, hi);
        chk(per == 6, "R6 clk0 period after wake", per, 6);

        // R7 R9: profile select, switch on period boundary
        pin_i = 1'b1;
        start(mk(2, 0, 0, 9, 40), mk(7, 0, 0, 20, 300), 2, 0);
        cyc(50);
        chk(ref_ratio_o == 8'd9, "R9 profile A reference ratio", int'(ref_ratio_o), 9);
        meas(1'b0, per, hi);
        chk(per == 4, "R7 profile A period", per, 4);
        watch(300, 40, 200, 2, 7, 1'b1, bad, pulses);
        chk(bad == 0, "R7 runt phase during switch", bad, 0);
        pin_i = 1'b0;
        cyc(60);
        meas(1'b0, per, hi);
        chk(per == 14, "R7 profile B period", per, 14);
        chk(fb_ratio_o == 12'd600, "R9 profile B feedback ratio", int'(fb_ratio_o), 600);

        // R8: source change between reference and synthesizer paths
        pin_i = 1'b1;
        start(mk(4, 1, 0, 1, 1), mk(5, 0, 0, 1, 1), 2, 0);
        cyc(50);
        watch(400, 100, 250, 3, 5, 1'b0, bad, pulses);
        chk(bad == 0, "R8 partial high pulse at source change", bad, 0);
        chk(pulses > 20, "R8 pulses seen across change", pulses, 21);

        summary();
        $finish;
    end

endmodule